// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with User Data Register

This block is the device-side test access port for one chip in a serial scan chain. A test controller drives the mode-select line (`tms`) and serial input (`tdi`) against the test clock. The block walks the standard sixteen-state controller graph on each rising `tck` edge and returns serial data on `tdo`. It holds a 3-bit instruction register and two data paths behind it. One is a single-bit bypass stage that lets scan data pass through this chip with one clock of delay. The other is a user data register of parameter width `UW`, which is chosen by opcode `010`.

The user register captures the parallel input `user_din` when a data scan starts. Its contents shift out least-significant bit first while new bits enter from `tdi`. When the scan completes, the shifted-in value is copied to `user_dout`. `tdo` changes on falling `tck`. It is enabled only while a shift state is active, and `tdo_oe` models the output buffer's enable.

Top module: `jtag_tap`

## Requirements
- R1: After `por_n` is released, the controller is in Test-Logic-Reset, the active instruction is 110, `tdo_oe` is 0 and `user_dout` is all zeros.
- R2: Holding `tms` at 1 for five consecutive rising `tck` edges brings the controller to Test-Logic-Reset from any state, so seven edges are always enough.
- R3: State changes follow the standard sixteen-state graph. A data scan may leave Shift-DR through Exit1-DR into Pause-DR and return to Shift-DR through Exit2-DR with its shift contents intact.
- R4: The instruction register is 3 bits. Capture-IR loads 001 into its shift stage, which shifts out least-significant bit first. The new opcode becomes active only in Update-IR.
- R5: Test-Logic-Reset forces the active instruction to 110, the bypass opcode.
- R6: Opcode 110, and every opcode other than 010, selects the bypass bit. It captures 0 in Capture-DR, so the first bit out is 0, and each later bit out equals the `tdi` bit shifted in one edge earlier.
- R7: Opcode 010 selects the user register. Capture-DR loads `user_din`, and shifting moves bit 0 out first with `tdi` entering at the top bit.
- R8: `user_dout` takes the user shift contents only in Update-DR while opcode 010 is active. It holds its value through all other scans and states.
- R9: `tdo` is updated on falling `tck`. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| user_din | input | UW | Parallel value captured into the user register |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo`, high only while shifting |
| user_dout | output | UW | Value latched from the user register at Update-DR |

## Verification
The hardest condition to reach from the ports is a data scan that is suspended in Pause-DR and then resumed. The shift contents must survive the detour, and `tdo_oe` must drop and come back. The bench reaches this with random pause positions inside random-length scans, under random opcodes. It also walks the controller through random `tms` sequences with `tdi` held low before forcing reset. That shows reset from arbitrary states and shows that stray Update states leave `user_dout` alone.

// File: rtl/jtag_tap.sv
module jtag_tap #(
  parameter int          UW      = 8,
  parameter logic [2:0]  BYP_OP  = 3'b110,
  parameter logic [2:0]  USER_OP = 3'b010,
  parameter logic [2:0]  IR_CAP  = 3'b001
) (
  input  logic          tck,
  input  logic          por_n,
  input  logic          tms,
  input  logic          tdi,
  input  logic [UW-1:0] user_din,
  output logic          tdo,
  output logic          tdo_oe,
  output logic [UW-1:0] user_dout
);

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SELDR, S_CAPDR, S_SHDR, S_EX1DR, S_PADR, S_EX2DR, S_UPDR,
    S_SELIR, S_CAPIR, S_SHIR, S_EX1IR, S_PAIR, S_EX2IR, S_UPIR
  } tap_st_t;

  tap_st_t       state, nxt;
  logic [2:0]    ir, ir_sh;
  logic          byp;
  logic [UW-1:0] ud_sh;
  logic          sel_user;

  assign sel_user = (ir == USER_OP);

  always_comb begin
    case (state)
      S_TLR:   nxt = tms ? S_TLR   : S_RTI;
      S_RTI:   nxt = tms ? S_SELDR : S_RTI;
      S_SELDR: nxt = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: nxt = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  nxt = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: nxt = tms ? S_UPDR  : S_PADR;
      S_PADR:  nxt = tms ? S_EX2DR : S_PADR;
      S_EX2DR: nxt = tms ? S_UPDR  : S_SHDR;
      S_UPDR:  nxt = tms ? S_SELDR : S_RTI;
      S_SELIR: nxt = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: nxt = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  nxt = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: nxt = tms ? S_UPIR  : S_PAIR;
      S_PAIR:  nxt = tms ? S_EX2IR : S_PAIR;
      S_EX2IR: nxt = tms ? S_UPIR  : S_SHIR;
      S_UPIR:  nxt = tms ? S_SELDR : S_RTI;
      default: nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= S_TLR;
    else        state <= nxt;
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sh <= IR_CAP;
      ir    <= BYP_OP;
    end else begin
      if (state == S_CAPIR)     ir_sh <= IR_CAP;
      else if (state == S_SHIR) ir_sh <= {tdi, ir_sh[2:1]};
      if (state == S_TLR)       ir <= BYP_OP;
      else if (state == S_UPIR) ir <= ir_sh;
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp       <= 1'b0;
      ud_sh     <= '0;
      user_dout <= '0;
    end else begin
      if (state == S_CAPDR)                   byp <= 1'b0;
      else if (state == S_SHDR && !sel_user)  byp <= tdi;
      if (sel_user) begin
        if (state == S_CAPDR)     ud_sh <= user_din;
        else if (state == S_SHDR) ud_sh <= {tdi, ud_sh[UW-1:1]};
        if (state == S_UPDR)      user_dout <= ud_sh;
      end
    end
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == S_SHIR) || (state == S_SHDR);
      tdo    <= (state == S_SHIR) ? ir_sh[0] : (sel_user ? ud_sh[0] : byp);
    end
  end

  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)       ones_q <= '0;
    else if (!tms)    ones_q <= '0;
    else if (ones_q != 3'd7) ones_q <= ones_q + 3'd1;
  end

  // R2
  tms_reset_chk: assert property (@(posedge tck) disable iff (!por_n)
    (ones_q >= 3'd5) |-> (state == S_TLR));

  // R5
  tlr_bypass_chk: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_TLR) |=> (ir == BYP_OP));

  // R4
  ir_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
    (state != S_UPIR && state != S_TLR) |=> $stable(ir));

  // R4
  ir_capture_chk: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_CAPIR) |=> (ir_sh == IR_CAP));

  // R8
  upd_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
    !(state == S_UPDR && sel_user) |=> $stable(user_dout));

  // R6
  byp_delay_chk: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_SHDR && !sel_user) |=> (byp == $past(tdi)));

  // R9
  oe_shift_chk: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe |-> (state == S_SHIR || state == S_SHDR));

endmodule

// File: tb/test_jtag_tap.sv
module test_jtag_tap;
  localparam int UW = 8;

  logic          tck = 1'b0;
  logic          por_n = 1'b0;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic [UW-1:0] user_din = '0;
  logic          tdo, tdo_oe;
  logic [UW-1:0] user_dout;

  int checks = 0;
  int errors = 0;

  always #4 tck = ~tck;

  jtag_tap #(.UW(UW)) i_jtag_tap (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .user_din(user_din),
    .tdo(tdo), .tdo_oe(tdo_oe), .user_dout(user_dout));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clk(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  function automatic logic [31:0] byp_exp(input logic [31:0] d, input int n);
    logic [31:0] m;
    m = (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    return (d << 1) & m;
  endfunction

  task automatic ir_scan(input logic [2:0] op, output logic [2:0] cap);
    clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      clk(i == 2, op[i]);
    end
    clk(1, 0); clk(0, 0);
  endtask

  task automatic dr_scan(input int n, input logic [31:0] din, input int pz,
                         output logic [31:0] dout);
    dout = '0;
    clk(1, 0); clk(0, 0); clk(0, 0);
    for (int i = 0; i < n; i++) begin
      if (i == 0) check("R9 oe high in Shift-DR", {31'd0, tdo_oe}, 32'd1);
      dout[i] = tdo;
      if (i == pz - 1 && i != n - 1) begin
        clk(1, din[i]); clk(0, 0); clk(0, 0);
        check("R9 oe low in Pause-DR", {31'd0, tdo_oe}, 32'd0);
        clk(1, 0); clk(0, 0);
      end else begin
        clk(i == n - 1, din[i]);
      end
    end
    clk(1, 0); clk(0, 0);
    check("R9 oe low after scan", {31'd0, tdo_oe}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0]    cap;
    logic [31:0]   dout, din;
    logic [2:0]    ir_m;
    logic [UW-1:0] ud_m;
    int            n, pz;
    void'($urandom(32'h5EED));

    repeat (3) @(negedge tck);
    #1;
    check("R1 oe at reset", {31'd0, tdo_oe}, 32'd0);
    check("R1 user_dout at reset", {24'd0, user_dout}, 32'd0);
    por_n = 1'b1;
    clk(0, 0);
    ir_m = 3'b110;
    ud_m = '0;

    din = 32'h0000_02D5;
    dr_scan(10, din, 0, dout);
    check("R1 R6 bypass after power-on", dout, byp_exp(din, 10));

    ir_scan(3'b010, cap);
    check("R4 IR capture pattern", {29'd0, cap}, 32'd1);
    ir_m = 3'b010;
    user_din = 8'hA6;
    din = 32'h0000_003C;
    dr_scan(UW, din, 0, dout);
    check("R7 user capture out LSB first", dout, 32'h0000_00A6);
    check("R8 user update", {24'd0, user_dout}, din);
    ud_m = din[UW-1:0];

    user_din = 8'h5B;
    din = 32'h0000_00C3;
    dr_scan(UW, din, 3, dout);
    check("R3 R7 scan with pause", dout, 32'h0000_005B);
    check("R3 R8 update after pause", {24'd0, user_dout}, din);
    ud_m = din[UW-1:0];

    ir_scan(3'b110, cap);
    check("R4 IR capture second", {29'd0, cap}, 32'd1);
    din = 32'h0000_9A71;
    dr_scan(16, din, 7, dout);
    check("R6 bypass with pause", dout, byp_exp(din, 16));
    check("R8 user_dout held in bypass", {24'd0, user_dout}, {24'd0, ud_m});

    ir_scan(3'b010, cap);
    repeat (5) clk(1, 0);
    clk(0, 0);
    din = 32'h0000_0013;
    dr_scan(5, din, 0, dout);
    check("R2 R5 five ones reset to bypass", dout, byp_exp(din, 5));
    check("R8 user_dout held over reset", {24'd0, user_dout}, {24'd0, ud_m});
    ir_m = 3'b110;

    for (int it = 0; it < 40; it++) begin
      if (($urandom % 5) == 0) begin
        ir_scan(3'b110, cap);
        for (int k = 0; k < 12; k++) clk(1'($urandom % 2), 0);
        repeat (7) clk(1, 0);
        clk(0, 0);
        ir_m = 3'b110;
        check("R8 user_dout held over walk", {24'd0, user_dout}, {24'd0, ud_m});
      end else begin
        ir_m = 3'($urandom);
        ir_scan(ir_m, cap);
        check("R4 IR capture random", {29'd0, cap}, 32'd1);
      end
      din = $urandom;
      user_din = UW'($urandom);
      if (ir_m == 3'b010) begin
        n = UW;
        pz = $urandom % UW;
        dr_scan(n, din, pz, dout);
        check("R7 user scan random", dout, {24'd0, user_din});
        ud_m = din[UW-1:0];
        check("R8 user update random", {24'd0, user_dout}, {24'd0, ud_m});
      end else begin
        n = 1 + ($urandom % 20);
        pz = $urandom % n;
        dr_scan(n, din, pz, dout);
        check("R6 bypass scan random", dout, byp_exp(din, n));
        check("R8 user_dout held random", {24'd0, user_dout}, {24'd0, ud_m});
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule